// File: doc/BRIEF.md
# Receive Character Buffer with Hysteresis Flow Control

This block sits between the receive deserializer of a UART channel and the host. Each assembled character reaches it together with three error flags, and it keeps them as one entry. It has two storage modes. In queue mode it holds up to 64 entries in arrival order. In holding mode it keeps a single entry. The host sees the oldest entry on its read port, together with a line-status byte. Each read strobe removes that entry.

A data-available interrupt fires once the fill level reaches a programmable trigger level. The block can also drive an active-low request-to-send line on its own. It releases the line once the fill climbs past the trigger level plus a hysteresis margin. It drives the line low again only once the fill drops below the trigger level minus that margin. Between the two marks the line keeps its last state, so the remote transmitter is paused and resumed without chatter.

Top module: `rx_char_buffer`

## Requirements
- R1: After a synchronous reset the fill level is 0, `line_stat` is 0, `rx_irq` is 0 and `rts_n` is 0 (asserted).
- R2: In queue mode (`fifo_en`=1) up to 64 entries are stored and returned in arrival order. `rd_data` shows the oldest byte, or 0 when the buffer is empty. A `rd_pop` on a non-empty buffer removes one entry. `fill_lvl` gives the entry count.
- R3: `line_stat` bit 0 is 1 while at least one entry is held. Bits 4:2 carry the three error flags of the oldest entry (`wr_err` bits 2:0 map to bits 4:2), or 0 when the buffer is empty. Bits 7:5 are 0.
- R4: A write that finds the buffer full, with no pop in the same cycle, is dropped and sets the sticky overrun bit `line_stat` bit 1. A `lsr_rd` strobe clears that bit. If an overrun and `lsr_rd` fall in the same cycle, the bit stays set.
- R5: A write and a pop in the same cycle are both accepted, even when the buffer is full. The fill level does not change, and no overrun is raised.
- R6: In holding mode (`fifo_en`=0) the capacity is one entry. Any change of `fifo_en` empties the buffer at the next clock edge, and the write and pop of that cycle are ignored.
- R7: `rx_irq` is 1 exactly when `rx_int_en` is 1 and the fill is at or above the effective trigger. In queue mode the effective trigger is `trig_lvl` limited to the range 1 to 64. In holding mode it is 1.
- R8: With automatic flow control on, `rts_n` goes to 1 in the same cycle the fill exceeds the high mark. The high mark is `trig_lvl`+`hyst_lvl`, limited to 64.
- R9: With automatic flow control on, `rts_n` goes to 0 in the same cycle the fill drops below the low mark. The low mark is `trig_lvl`−`hyst_lvl`, limited to 0. For fills from the low mark up to the high mark, the line keeps the state it had after the previous clock edge.
- R10: Automatic flow control is on only while both `flow_feat_en` and `flow_mcr_en` are 1. Otherwise `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Character from deserializer is valid this cycle |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Error flags of the received byte |
| rd_pop | input | 1 | Host removes the oldest entry |
| lsr_rd | input | 1 | Host reads line status (clears overrun) |
| fifo_en | input | 1 | 1 = 64-entry queue mode, 0 = holding mode |
| rx_int_en | input | 1 | Receive-data interrupt enable |
| flow_feat_en | input | 1 | Feature enable for automatic flow control |
| flow_mcr_en | input | 1 | Modem-control enable for automatic flow control |
| trig_lvl | input | 7 | Programmed trigger level |
| hyst_lvl | input | 7 | Programmed hysteresis margin |
| rd_data | output | 8 | Oldest byte held |
| line_stat | output | 8 | Line status byte |
| fill_lvl | output | 7 | Number of entries held |
| rx_irq | output | 1 | Receive data-available interrupt |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
Two pairs of events can fall in the same cycle. The first is a write and a host pop while the buffer is full: whether the character is accepted decides between an overrun and a steady fill. The second is an overrun event and a line-status read: the bench must show whether the sticky flag survives. Directed steps fill the buffer to 64 and then drive both strobes together, and a random phase issues writes, pops and status reads at independent rates. The bench judges each cycle against a reference queue. It also keeps a reference overrun flag in which a set beats a clear.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // upper flow mark, limited to the storage depth
    function automatic int hi_mark(int trig, int hyst, int depth);
        return (trig + hyst > depth) ? depth : trig + hyst;
    endfunction

    // lower flow mark, limited at zero
    function automatic int lo_mark(int trig, int hyst);
        return (trig > hyst) ? trig - hyst : 0;
    endfunction

    // interrupt trigger after mode and range limiting
    function automatic int eff_trigger(int trig, int depth, logic queue_mode);
        if (!queue_mode) return 1;
        if (trig < 1)     return 1;
        if (trig > depth) return depth;
        return trig;
    endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      cap_one,
    input  logic      push_req,
    input  rx_entry_t wr_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic [CW-1:0] count,
    output logic      ovr_evt
);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cap;
    logic          full, push_ok, pop_ok;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = cap_one ? CW'(1) : CW'(DEPTH);
    assign full    = (count >= cap);
    assign pop_ok  = pop_req && (count != '0);
    assign push_ok = push_req && (!full || pop_ok);
    assign ovr_evt = push_req && !push_ok;
    assign head    = (count != '0) ? mem[rptr] : '0;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (pop_ok)  rptr <= step(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_hold_cap_r6: assert property (@(posedge clk) disable iff (rst)
        cap_one |-> count <= CW'(1));

    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !flush && count < cap) |=> count == $past(count) + 1'b1);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !flush && full) |=> count == $past(count));

    p_swap_full_r5: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !flush && full) |=> count == $past(count));

endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    fill,
    input  logic [CW-1:0]    trig_eff,
    input  logic             int_en,
    input  logic             ovr_evt,
    input  logic             lsr_rd,
    input  logic [ERR_W-1:0] head_err,
    output logic             irq,
    output logic [7:0]       lsr
);

    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst)          ovr_q <= 1'b0;
        else if (ovr_evt) ovr_q <= 1'b1;
        else if (lsr_rd)  ovr_q <= 1'b0;
    end

    assign irq = int_en && (fill >= trig_eff);
    assign lsr = {3'b000, head_err, ovr_q, (fill != '0)};

    p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> lsr[1]);

    p_ovr_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !ovr_evt) |=> !lsr[1]);

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!int_en || fill == '0) |-> !irq);

endmodule

// File: rtl/rxb_rts.sv
module rxb_rts #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_en,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    output logic          rts_n
);

    logic off_q, off_now;

    // above high mark: release; below low mark: request; else keep
    always_comb begin
        if (fill > hi)      off_now = 1'b1;
        else if (fill < lo) off_now = 1'b0;
        else                off_now = off_q;
    end

    always_ff @(posedge clk) begin
        if (rst) off_q <= 1'b0;
        else     off_q <= auto_en ? off_now : 1'b0;
    end

    assign rts_n = auto_en && off_now;

    p_rts_off_r8: assert property (@(posedge clk) disable iff (rst)
        (auto_en && fill > hi) |-> rts_n);

    p_rts_on_r9: assert property (@(posedge clk) disable iff (rst)
        (auto_en && fill < lo) |-> !rts_n);

    p_rts_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (auto_en && fill >= lo && fill <= hi) |=>
            (!auto_en || fill < lo || fill > hi || rts_n == $past(rts_n)));

    p_rts_manual_r10: assert property (@(posedge clk) disable iff (rst)
        !auto_en |-> !rts_n);

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_pop,
    input  logic              lsr_rd,
    input  logic              fifo_en,
    input  logic              rx_int_en,
    input  logic              flow_feat_en,
    input  logic              flow_mcr_en,
    input  logic [CW-1:0]     trig_lvl,
    input  logic [CW-1:0]     hyst_lvl,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        line_stat,
    output logic [CW-1:0]     fill_lvl,
    output logic              rx_irq,
    output logic              rts_n
);

    logic          mode_q, flush, ovr_evt;
    rx_entry_t     wr_entry, head;
    logic [CW-1:0] count, trig_eff, hi_w, lo_w;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= fifo_en;
        else     mode_q <= fifo_en;
    end

    assign flush    = !rst && (fifo_en != mode_q);
    assign wr_entry = '{err: wr_err, data: wr_data};

    assign trig_eff = CW'(eff_trigger(int'(trig_lvl), DEPTH, mode_q));
    assign hi_w     = CW'(hi_mark(int'(trig_lvl), int'(hyst_lvl), DEPTH));
    assign lo_w     = CW'(lo_mark(int'(trig_lvl), int'(hyst_lvl)));

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .cap_one  (!mode_q),
        .push_req (wr_valid && !flush),
        .wr_entry (wr_entry),
        .pop_req  (rd_pop && !flush),
        .head     (head),
        .count    (count),
        .ovr_evt  (ovr_evt)
    );

    rxb_status #(.DEPTH(DEPTH)) u_status (
        .clk      (clk),
        .rst      (rst),
        .fill     (count),
        .trig_eff (trig_eff),
        .int_en   (rx_int_en),
        .ovr_evt  (ovr_evt),
        .lsr_rd   (lsr_rd),
        .head_err (head.err),
        .irq      (rx_irq),
        .lsr      (line_stat)
    );

    rxb_rts #(.DEPTH(DEPTH)) u_rts (
        .clk     (clk),
        .rst     (rst),
        .auto_en (flow_feat_en && flow_mcr_en),
        .fill    (count),
        .hi      (hi_w),
        .lo      (lo_w),
        .rts_n   (rts_n)
    );

    assign rd_data  = head.data;
    assign fill_lvl = count;

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> fill_lvl == '0);

endmodule

// File: tb/rx_char_buffer_test.sv
module rx_char_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 0, rd_pop = 0, lsr_rd = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] wr_err = 0;
    logic       fifo_en = 1, rx_int_en = 1, flow_feat_en = 1, flow_mcr_en = 1;
    logic [6:0] trig_lvl = 7'd48, hyst_lvl = 7'd8;
    logic [7:0] rd_data, line_stat;
    logic [6:0] fill_lvl;
    logic       rx_irq, rts_n;

    int checks = 0, bad = 0;
    bit done = 0;

    logic [10:0] mq[$];
    bit  m_mode, m_ovr, m_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_char_buffer uut (.*);

    function automatic int f_hi(int t, int h); return (t + h > DEPTH) ? DEPTH : t + h; endfunction
    function automatic int f_lo(int t, int h); return (t > h) ? t - h : 0; endfunction
    function automatic int f_trig(int t, bit qm);
        if (!qm) return 1;
        return (t < 1) ? 1 : (t > DEPTH) ? DEPTH : t;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference update at the clock edge, from pre-edge state and inputs
    task automatic model_edge();
        int  n;
        bit  auto_on, evt, pop_ok, push_ok, now_off;
        n = mq.size();
        evt = 0;
        if (rst) begin
            mq.delete(); m_ovr = 0; m_off = 0; m_mode = fifo_en;
            return;
        end
        auto_on = flow_feat_en && flow_mcr_en;
        if (n > f_hi(trig_lvl, hyst_lvl))      now_off = 1;
        else if (n < f_lo(trig_lvl, hyst_lvl)) now_off = 0;
        else                                   now_off = m_off;
        m_off = auto_on ? now_off : 0;
        if (fifo_en != m_mode) begin
            mq.delete(); m_mode = fifo_en;
        end else begin
            pop_ok  = rd_pop && n > 0;
            push_ok = wr_valid && (n < (m_mode ? DEPTH : 1) || pop_ok);
            evt     = wr_valid && !push_ok;
            if (pop_ok)  void'(mq.pop_front());
            if (push_ok) mq.push_back({wr_err, wr_data});
        end
        if (evt) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
    endtask

    task automatic check_all();
        int  n, eh;
        bit  auto_on, off;
        n = mq.size();
        eh = (n > 0) ? int'(mq[0][10:8]) : 0;
        chk("R2 fill", fill_lvl, n);
        chk("R2 rd_data", rd_data, (n > 0) ? int'(mq[0][7:0]) : 0);
        chk("R3 line_stat", line_stat, (eh << 2) | (int'(m_ovr) << 1) | int'(n > 0));
        chk("R7 rx_irq", rx_irq, int'(rx_int_en && n >= f_trig(trig_lvl, m_mode)));
        auto_on = flow_feat_en && flow_mcr_en;
        if (n > f_hi(trig_lvl, hyst_lvl))      off = 1;
        else if (n < f_lo(trig_lvl, hyst_lvl)) off = 0;
        else                                   off = m_off;
        chk("R8 rts_n", rts_n, int'(auto_on && off));
    endtask

    task automatic cyc(bit wv, bit rp, bit lr);
        wr_valid = wv; rd_pop = rp; lsr_rd = lr;
        wr_data = 8'($urandom); wr_err = 3'($urandom);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        rst = 1; cyc(0, 0, 0); cyc(0, 0, 0);
        rst = 0;
        // R1 reset state
        chk("R1 fill", fill_lvl, 0);
        chk("R1 line_stat", line_stat, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 rts_n", rts_n, 0);

        // fill to thresholds: trigger 48, margin 8
        for (int i = 0; i < 47; i++) cyc(1, 0, 0);
        chk("R7 below trigger", rx_irq, 0);
        cyc(1, 0, 0);
        chk("R7 at trigger", rx_irq, 1);
        for (int i = 0; i < 8; i++) cyc(1, 0, 0);
        chk("R8 at high mark", rts_n, 0);
        cyc(1, 0, 0);
        chk("R8 above high mark", rts_n, 1);
        while (mq.size() < DEPTH) cyc(1, 0, 0);
        chk("R2 full", fill_lvl, 64);
        cyc(1, 0, 0);
        chk("R4 dropped", fill_lvl, 64);
        chk("R4 overrun set", line_stat[1], 1);
        cyc(0, 0, 1);
        chk("R4 overrun cleared", line_stat[1], 0);
        cyc(1, 1, 0);
        chk("R5 swap keeps fill", fill_lvl, 64);
        chk("R5 no overrun", line_stat[1], 0);
        cyc(1, 0, 1);
        chk("R4 set beats clear", line_stat[1], 1);
        cyc(0, 0, 1);

        // drain through hysteresis band
        while (mq.size() > 40) cyc(0, 1, 0);
        chk("R9 hold at low mark", rts_n, 1);
        cyc(0, 1, 0);
        chk("R9 below low mark", rts_n, 0);
        for (int i = 0; i < 10; i++) cyc(1, 0, 0);
        chk("R9 hold rising", rts_n, 0);

        // one enable bit only
        flow_mcr_en = 0;
        while (mq.size() < DEPTH) cyc(1, 0, 0);
        chk("R10 manual rts", rts_n, 0);
        flow_mcr_en = 1; flow_feat_en = 0;
        cyc(0, 0, 0);
        chk("R10 manual rts feat", rts_n, 0);
        flow_feat_en = 1;

        // holding mode
        fifo_en = 0;
        cyc(1, 1, 0);
        chk("R6 flush", fill_lvl, 0);
        cyc(1, 0, 0);
        chk("R6 one held", fill_lvl, 1);
        chk("R7 holding trigger", rx_irq, 1);
        cyc(1, 0, 0);
        chk("R6 capacity one", fill_lvl, 1);
        chk("R4 holding overrun", line_stat[1], 1);
        cyc(0, 1, 1);
        fifo_en = 1;
        cyc(0, 0, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) begin
                trig_lvl = 7'($urandom_range(0, 70));
                hyst_lvl = 7'($urandom_range(0, 20));
                rx_int_en = 1'($urandom);
                flow_feat_en = ($urandom_range(0, 3) != 0);
                flow_mcr_en  = ($urandom_range(0, 3) != 0);
            end
            if (i % 1500 == 1499) fifo_en = ~fifo_en;
            cyc(($urandom_range(0, 99) < ((i / 250) % 2 ? 70 : 35)),
                ($urandom_range(0, 99) < 50),
                ($urandom_range(0, 99) < 10));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule